// File: doc/BRIEF.md
# Cluster Coherence Directory Controller

This block keeps a directory for the lines of local memory that are held in the caches of other clusters, and it serves incoming memory requests against that directory. Each entry records a line address, a coherence state and a bit vector with one bit per cluster that holds a copy. A request is looked up in the directory. Then invalidate or fetch-dirty messages go out to the clusters that must give up or return the line. The controller counts their acknowledgements, updates the entry, and only then replies to the requester.

Requests come in as read, write or release. A release means a cluster has dropped its copy. All message ports are valid/ready channels. The directory is a small, fully associative table. The controller serves one transaction at a time, so a line can never have two transactions in flight. A request for a new line while every entry is in use is held at the request port until an entry frees up.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset the directory is empty: no message and no reply is pending, and reqReady is high for a request of any kind.
- R2: A read (reqOp 0) of a line with no entry allocates an entry in the Exclusive state with the reader as its only holder. The read is answered without any message.
- R3: A read by another cluster of a line that is Exclusive or Shared adds the reader to the holders and leaves the line Shared. No message is sent.
- R4: A write (reqOp 1) to a line that is not Modified sends an invalidate (msgKind 0) to every other holder and none to the writer. Afterwards the line is Modified with the writer as its only holder. A write by the sole holder sends nothing.
- R5: A read or write by another cluster of a Modified line sends exactly one fetch (msgKind 1) to the owner. After a read, the owner and the reader share the line. After a write, the writer alone holds it Modified.
- R6: Messages for one request leave in strictly ascending cluster number, one per accepted handshake. While msgReady is low, msgValid, msgDest and msgKind are held.
- R7: The reply (rspValid) comes only after one acknowledgement has been received for every message sent. It carries the requesting cluster and the line address, and it is held until rspReady.
- R8: A release (reqOp 2) removes the cluster from the holders, and the entry is freed when no holder remains. A later write by another cluster to that line then sends no message. A release of a line with no entry changes nothing.
- R9: When every entry is in use, a read or write of a line with no entry is stalled (reqReady low) until an entry is freed. Requests to lines already present, and releases, are still accepted.
- R10: From the cycle a request is accepted until its reply is taken, reqReady stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted this cycle when high with reqValid |
| reqOp | input | 2 | 0 read, 1 write, 2 release |
| reqCluster | input | CID_W | Requesting cluster |
| reqAddr | input | ADDR_W | Line address |
| msgValid | output | 1 | Outgoing coherence message valid |
| msgReady | input | 1 | Network takes the message |
| msgKind | output | 1 | 0 invalidate, 1 fetch dirty line |
| msgDest | output | CID_W | Target cluster |
| msgAddr | output | ADDR_W | Line address of the message |
| ackValid | input | 1 | Acknowledgement from a target cluster |
| ackReady | output | 1 | Acknowledgements accepted |
| rspValid | output | 1 | Reply to the requester valid |
| rspReady | input | 1 | Requester takes the reply |
| rspCluster | output | CID_W | Cluster the reply goes to |
| rspAddr | output | ADDR_W | Line address of the reply |

## Verification
The assertions assume that acknowledgements answer messages already sent: ackValid is never raised with no message outstanding. They also assume that inputs change only between clock edges. The bench drives acknowledgements only for messages it has already seen accepted, and it drives them one cycle apart, so the outstanding count the checker keeps never goes negative. The bench toggles msgReady and rspReady in a fixed pattern. This exercises the hold rules without breaking the channel protocol.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

  typedef enum logic [1:0] {
    OP_READ    = 2'd0,
    OP_WRITE   = 2'd1,
    OP_RELEASE = 2'd2
  } reqOp_e;

  typedef enum logic [1:0] {
    ST_SHARED = 2'd1,
    ST_EXCL   = 2'd2,
    ST_MOD    = 2'd3
  } lineSt_e;

  localparam logic MSG_INVAL = 1'b0;
  localparam logic MSG_FETCH = 1'b1;

  typedef struct packed {
    logic capture;
    logic sendFire;
    logic ackFire;
    logic commit;
  } dirStrobe_t;

endpackage

// File: rtl/coh_dir_datapath.sv
module coh_dir_datapath
  import coh_dir_pkg::*;
#(
  parameter int NCL     = 8,
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 8,
  localparam int CID_W  = (NCL > 1) ? $clog2(NCL) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dirStrobe_t        stb,
  input  logic [1:0]        reqOp,
  input  logic [CID_W-1:0]  reqCluster,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              lookHit,
  output logic              dirFull,
  output logic              pendEmpty,
  output logic              cntZero,
  output logic [CID_W-1:0]  msgDest,
  output logic              msgKind,
  output logic [CID_W-1:0]  latCluster,
  output logic [ADDR_W-1:0] latAddr
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNT_W = $clog2(NCL + 1);

  // directory storage
  logic              entValid [ENTRIES];
  logic [ADDR_W-1:0] entAddr  [ENTRIES];
  logic [NCL-1:0]    entSh    [ENTRIES];
  lineSt_e           entSt    [ENTRIES];

  // lookup of the incoming request
  logic [IDX_W-1:0] hitIdx, freeIdx;
  logic [NCL-1:0]   hitSh, reqBit, targets;
  lineSt_e          hitSt;
  logic             needMsg;

  always_comb begin
    lookHit = 1'b0;
    hitIdx  = '0;
    hitSh   = '0;
    hitSt   = ST_SHARED;
    for (int i = 0; i < ENTRIES; i++) begin
      if (entValid[i] && entAddr[i] == reqAddr) begin
        lookHit = 1'b1;
        hitIdx  = IDX_W'(i);
        hitSh   = entSh[i];
        hitSt   = entSt[i];
      end
    end
  end

  always_comb begin
    freeIdx = '0;
    dirFull = 1'b1;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!entValid[i]) begin
        freeIdx = IDX_W'(i);
        dirFull = 1'b0;
      end
    end
  end

  always_comb begin
    reqBit = '0;
    reqBit[reqCluster] = 1'b1;
  end

  assign targets = hitSh & ~reqBit;

  always_comb begin
    needMsg = 1'b0;
    if (lookHit && targets != '0) begin
      if (reqOp == OP_WRITE) needMsg = 1'b1;
      else if (reqOp == OP_READ && hitSt == ST_MOD) needMsg = 1'b1;
    end
  end

  // latched transaction
  logic [1:0]       lOp;
  logic             lHit;
  logic [IDX_W-1:0] lIdx, lFree;
  logic [NCL-1:0]   lSh, lBit, pend;
  lineSt_e          lSt;
  logic [CNT_W-1:0] outCnt;
  logic             lKind;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lOp        <= '0;
      lHit       <= 1'b0;
      lIdx       <= '0;
      lFree      <= '0;
      lSh        <= '0;
      lBit       <= '0;
      lSt        <= ST_SHARED;
      lKind      <= MSG_INVAL;
      latCluster <= '0;
      latAddr    <= '0;
    end else if (stb.capture) begin
      lOp        <= reqOp;
      lHit       <= lookHit;
      lIdx       <= hitIdx;
      lFree      <= freeIdx;
      lSh        <= hitSh;
      lBit       <= reqBit;
      lSt        <= hitSt;
      lKind      <= (hitSt == ST_MOD) ? MSG_FETCH : MSG_INVAL;
      latCluster <= reqCluster;
      latAddr    <= reqAddr;
    end
  end

  always_comb begin
    msgDest = '0;
    for (int i = NCL - 1; i >= 0; i--) begin
      if (pend[i]) msgDest = CID_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend <= '0;
    end else if (stb.capture) begin
      pend <= needMsg ? targets : '0;
    end else if (stb.sendFire) begin
      pend <= pend & ~(NCL'(1) << msgDest);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCnt <= '0;
    end else begin
      case ({stb.sendFire, stb.ackFire && outCnt != '0})
        2'b10:   outCnt <= outCnt + CNT_W'(1);
        2'b01:   outCnt <= outCnt - CNT_W'(1);
        default: outCnt <= outCnt;
      endcase
    end
  end

  assign pendEmpty = (pend == '0);
  assign cntZero   = (outCnt == '0);
  assign msgKind   = lKind;

  // directory update at commit
  logic             doWrite, doFree;
  logic [IDX_W-1:0] wrIdx;
  logic [NCL-1:0]   newSh;
  lineSt_e          newSt;

  always_comb begin
    doWrite = 1'b0;
    doFree  = 1'b0;
    wrIdx   = lHit ? lIdx : lFree;
    newSh   = lSh;
    newSt   = lSt;
    case (lOp)
      OP_READ: begin
        doWrite = 1'b1;
        if (!lHit) begin
          newSh = lBit;
          newSt = ST_EXCL;
        end else begin
          newSh = lSh | lBit;
          newSt = ($countones(newSh) == 1) ? lSt : ST_SHARED;
        end
      end
      OP_WRITE: begin
        doWrite = 1'b1;
        newSh   = lBit;
        newSt   = ST_MOD;
      end
      OP_RELEASE: begin
        if (lHit) begin
          newSh = lSh & ~lBit;
          if (newSh == '0) doFree = 1'b1;
          else begin
            doWrite = 1'b1;
            newSt = ($countones(newSh) == 1 && lSt != ST_MOD) ? ST_EXCL : lSt;
          end
        end
      end
      default: ;
    endcase
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic sel;
    assign sel = stb.commit && (wrIdx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entValid[e] <= 1'b0;
        entAddr[e]  <= '0;
        entSh[e]    <= '0;
        entSt[e]    <= ST_SHARED;
      end else if (sel && doWrite) begin
        entValid[e] <= 1'b1;
        entAddr[e]  <= latAddr;
        entSh[e]    <= newSh;
        entSt[e]    <= newSt;
      end else if (sel && doFree) begin
        entValid[e] <= 1'b0;
        entSh[e]    <= '0;
      end
    end
  end

endmodule

// File: rtl/coh_dir_control.sv
module coh_dir_control
  import coh_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       lookHit,
  input  logic       dirFull,
  input  logic       pendEmpty,
  input  logic       cntZero,
  input  logic       msgReady,
  input  logic       ackValid,
  input  logic       rspReady,
  output dirStrobe_t stb,
  output logic       reqReady,
  output logic       msgValid,
  output logic       ackReady,
  output logic       rspValid
);

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_WAIT, S_COMMIT, S_RESP} ctrlSt_e;
  ctrlSt_e state, stateNext;

  assign reqReady = (state == S_IDLE) && !(dirFull && !lookHit && reqOp != OP_RELEASE);
  assign msgValid = (state == S_SEND) && !pendEmpty;
  assign ackReady = (state == S_SEND) || (state == S_WAIT);
  assign rspValid = (state == S_RESP);

  always_comb begin
    stb          = '0;
    stb.capture  = reqValid && reqReady;
    stb.sendFire = msgValid && msgReady;
    stb.ackFire  = ackValid && ackReady;
    stb.commit   = (state == S_COMMIT);
  end

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:   if (stb.capture) stateNext = S_SEND;
      S_SEND:   if (pendEmpty) stateNext = S_WAIT;
      S_WAIT:   if (cntZero) stateNext = S_COMMIT;
      S_COMMIT: stateNext = S_RESP;
      S_RESP:   if (rspReady) stateNext = S_IDLE;
      default:  stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
  import coh_dir_pkg::*;
#(
  parameter int NCL     = 8,
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 8,
  localparam int CID_W  = (NCL > 1) ? $clog2(NCL) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [CID_W-1:0]  reqCluster,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              msgValid,
  input  logic              msgReady,
  output logic              msgKind,
  output logic [CID_W-1:0]  msgDest,
  output logic [ADDR_W-1:0] msgAddr,
  input  logic              ackValid,
  output logic              ackReady,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [CID_W-1:0]  rspCluster,
  output logic [ADDR_W-1:0] rspAddr
);

  dirStrobe_t        stb;
  logic              lookHit, dirFull, pendEmpty, cntZero;
  logic [CID_W-1:0]  latCluster;
  logic [ADDR_W-1:0] latAddr;

  coh_dir_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .lookHit(lookHit), .dirFull(dirFull), .pendEmpty(pendEmpty), .cntZero(cntZero),
    .msgReady(msgReady), .ackValid(ackValid), .rspReady(rspReady),
    .stb(stb), .reqReady(reqReady), .msgValid(msgValid),
    .ackReady(ackReady), .rspValid(rspValid)
  );

  coh_dir_datapath #(.NCL(NCL), .ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqOp(reqOp),
    .reqCluster(reqCluster), .reqAddr(reqAddr),
    .lookHit(lookHit), .dirFull(dirFull), .pendEmpty(pendEmpty), .cntZero(cntZero),
    .msgDest(msgDest), .msgKind(msgKind),
    .latCluster(latCluster), .latAddr(latAddr)
  );

  assign msgAddr    = latAddr;
  assign rspCluster = latCluster;
  assign rspAddr    = latAddr;

endmodule

// File: rtl/coh_dir_ctrl_chk.sv
module coh_dir_ctrl_chk #(
  parameter int NCL     = 8,
  parameter int ADDR_W  = 8,
  localparam int CID_W  = (NCL > 1) ? $clog2(NCL) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [CID_W-1:0]  reqCluster,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              msgValid,
  input logic              msgReady,
  input logic              msgKind,
  input logic [CID_W-1:0]  msgDest,
  input logic              ackValid,
  input logic              ackReady,
  input logic              rspValid,
  input logic              rspReady,
  input logic [CID_W-1:0]  rspCluster,
  input logic [ADDR_W-1:0] rspAddr
);

  localparam int CNT_W = $clog2(NCL + 2);

  logic              busy;
  logic [CID_W-1:0]  capCl;
  logic [ADDR_W-1:0] capAddr;
  logic [CNT_W-1:0]  owed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      capCl   <= '0;
      capAddr <= '0;
    end else if (reqValid && reqReady) begin
      busy    <= 1'b1;
      capCl   <= reqCluster;
      capAddr <= reqAddr;
    end else if (rspValid && rspReady) begin
      busy    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) owed <= '0;
    else begin
      case ({msgValid && msgReady, ackValid && ackReady && owed != '0})
        2'b10:   owed <= owed + CNT_W'(1);
        2'b01:   owed <= owed - CNT_W'(1);
        default: owed <= owed;
      endcase
    end
  end

  // R10
  busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqReady);

  // R4
  no_self_msg_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (busy && msgDest != capCl));

  // R7
  rsp_after_acks_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> owed == '0);

  // R7
  rsp_matches_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (busy && rspCluster == capCl && rspAddr == capAddr));

  // R6
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgDest) && $stable(msgKind)));

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid);

endmodule

bind coh_dir_ctrl coh_dir_ctrl_chk #(.NCL(NCL), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqCluster(reqCluster), .reqAddr(reqAddr),
  .msgValid(msgValid), .msgReady(msgReady), .msgKind(msgKind), .msgDest(msgDest),
  .ackValid(ackValid), .ackReady(ackReady),
  .rspValid(rspValid), .rspReady(rspReady),
  .rspCluster(rspCluster), .rspAddr(rspAddr)
);

// File: tb/tb_coh_dir_ctrl.sv
module tb_coh_dir_ctrl;

  localparam int NCL = 4;
  localparam int ENT = 4;
  localparam int AW  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [1:0] reqOp = '0;
  logic [1:0] reqCluster = '0;
  logic [AW-1:0] reqAddr = '0;
  logic msgValid, msgReady = 1'b1, msgKind;
  logic [1:0] msgDest;
  logic [AW-1:0] msgAddr;
  logic ackValid = 1'b0, ackReady;
  logic rspValid, rspReady = 1'b1;
  logic [1:0] rspCluster;
  logic [AW-1:0] rspAddr;

  always #5 clk = ~clk;

  coh_dir_ctrl #(.NCL(NCL), .ENTRIES(ENT), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqCluster(reqCluster), .reqAddr(reqAddr),
    .msgValid(msgValid), .msgReady(msgReady), .msgKind(msgKind),
    .msgDest(msgDest), .msgAddr(msgAddr),
    .ackValid(ackValid), .ackReady(ackReady),
    .rspValid(rspValid), .rspReady(rspReady),
    .rspCluster(rspCluster), .rspAddr(rspAddr)
  );

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  // reference directory: holder mask and state (1 shared, 2 exclusive, 3 modified)
  logic [3:0] mSh [256];
  int         mSt [256];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  task automatic modelUpdate(input int op, input int cl, input int addr);
    logic [3:0] b, ns;
    b = 4'(1 << cl);
    if (op == 0) begin
      if (mSh[addr] == 0) begin mSh[addr] = b; mSt[addr] = 2; end
      else begin
        ns = mSh[addr] | b;
        if ($countones(ns) != 1) mSt[addr] = 1;
        mSh[addr] = ns;
      end
    end else if (op == 1) begin
      mSh[addr] = b; mSt[addr] = 3;
    end else if (mSh[addr] != 0) begin
      ns = mSh[addr] & ~b;
      if (ns != 0 && $countones(ns) == 1 && mSt[addr] != 3) mSt[addr] = 2;
      mSh[addr] = ns;
    end
  endtask

  task automatic doReq(input int op, input int cl, input int addr);
    logic [3:0] b, tgt, expMask, gotMask;
    bit hit, isMod, orderOk, kindOk, busyOk, rspOk;
    int expCnt, seen, acked, lastDest, waitN, expKind;
    string tag;
    b = 4'(1 << cl);
    hit = (mSh[addr] != 0);
    isMod = hit && mSt[addr] == 3;
    tgt = mSh[addr] & ~b;
    expMask = ((op == 1 && hit) || (op == 0 && isMod)) ? tgt : 4'b0;
    expKind = isMod ? 1 : 0;
    expCnt = $countones(expMask);
    if (op == 2) tag = "R8";
    else if (!hit) tag = "R2";
    else if (isMod && tgt != 0) tag = "R5";
    else if (op == 1) tag = "R4";
    else tag = "R3";

    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'(op); reqCluster = 2'(cl); reqAddr = AW'(addr);
    #1;
    waitN = 0;
    while (!reqReady && waitN < 100) begin @(negedge clk); #1; waitN++; end
    check(reqReady, tag, "request accepted", int'(reqReady), 1);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;

    gotMask = '0; seen = 0; acked = 0; lastDest = -1;
    orderOk = 1; kindOk = 1; busyOk = 1; rspOk = 0;
    for (int c = 0; c < 300 && !rspOk; c++) begin
      if (reqReady) busyOk = 0;
      if (ackValid) begin acked++; ackValid = 1'b0; end
      else if (acked < seen) ackValid = 1'b1;
      msgReady = (c % 3 != 1);
      rspReady = (c % 4 != 2);
      if (msgValid && msgReady) begin
        if (int'(msgDest) <= lastDest || gotMask[msgDest]) orderOk = 0;
        gotMask[msgDest] = 1'b1;
        if (int'(msgKind) != expKind || int'(msgAddr) != addr) kindOk = 0;
        lastDest = int'(msgDest);
        seen++;
      end
      if (rspValid && rspReady) begin
        rspOk = 1;
        check(acked == expCnt, "R7", "acks before reply", acked, expCnt);
        check(int'(rspCluster) == cl && int'(rspAddr) == addr, "R7", "reply fields",
              int'({rspCluster, rspAddr}), int'({2'(cl), AW'(addr)}));
      end
      @(negedge clk);
    end
    msgReady = 1'b1; rspReady = 1'b1; ackValid = 1'b0;
    check(rspOk, "R7", "reply issued", int'(rspOk), 1);
    check(gotMask == expMask, tag, "message targets", int'(gotMask), int'(expMask));
    check(kindOk, tag, "message kind and address", int'(kindOk), 1);
    check(orderOk, "R6", "ascending distinct targets", int'(orderOk), 1);
    check(busyOk, "R10", "reqReady low while busy", int'(busyOk), 1);
    modelUpdate(op, cl, addr);
  endtask

  task automatic cleanup(input int addr);
    for (int c = 0; c < NCL; c++)
      if (mSh[addr][c]) doReq(2, c, addr);
  endtask

  initial begin
    int seed;
    for (int i = 0; i < 256; i++) begin mSh[i] = '0; mSt[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R1
    check(reqReady == 1'b1, "R1", "reqReady after reset", int'(reqReady), 1);
    check(msgValid == 1'b0, "R1", "msgValid after reset", int'(msgValid), 0);
    check(rspValid == 1'b0, "R1", "rspValid after reset", int'(rspValid), 0);

    doReq(0, 0, 'h10);   // R2 miss -> exclusive
    doReq(0, 1, 'h10);   // R3 add sharer
    doReq(0, 2, 'h10);   // R3
    doReq(1, 1, 'h10);   // R4 invalidate 0 and 2
    doReq(0, 3, 'h10);   // R5 fetch from 1
    doReq(1, 3, 'h10);   // R4 invalidate 1
    doReq(1, 0, 'h10);   // R5 fetch from 3 on write
    doReq(1, 0, 'h10);   // R4 sole writer, no messages
    doReq(2, 0, 'h10);   // R8 last holder frees
    doReq(1, 2, 'h10);   // R8 no messages after free
    doReq(2, 1, 'h33);   // R8 release of absent line
    doReq(0, 1, 'h33);   // R2
    cleanup('h10);
    cleanup('h33);

    // R9 full directory
    for (int a = 0; a < ENT; a++) doReq(0, 0, 'h40 + a);
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd0; reqCluster = 2'd1; reqAddr = 8'h44;
    begin
      bit stalled;
      stalled = 1;
      for (int k = 0; k < 10; k++) begin #1; if (reqReady) stalled = 0; @(negedge clk); end
      check(stalled, "R9", "new line stalled when full", int'(!stalled), 0);
    end
    reqValid = 1'b0;
    doReq(0, 1, 'h40);   // R9 present line accepted while full
    doReq(2, 0, 'h40);   // R9 release accepted while full
    doReq(2, 1, 'h40);
    doReq(0, 1, 'h44);   // R9 accepted after an entry frees
    for (int a = 1; a <= ENT; a++) cleanup('h40 + a);

    // sweep over three lines, four clusters, all operations
    seed = 32'h1234567;
    for (int i = 0; i < 400; i++) begin
      int r;
      seed = seed * 1103515245 + 12345;
      r = (seed >>> 16) & 32'h7fff;
      doReq(r % 3, (r / 3) % NCL, 'h50 + (r / 12) % 3);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule